// File: doc/BRIEF.md
# Low-Power Mode Clock Enable Controller

This block produces the clock-enable strobes of a small microcontroller from its single main clock. It drives three enables: a level that lets the CPU advance its instructions, a sub-main clock enable from a divider or taken straight from the main clock, and an auxiliary low-rate enable from a slower divider. Three low-power request bits from the processor status image can halt each domain separately. The bits are captured into a register that reset clears, so every domain runs after reset.

Service requests can override the low-power bits. An interrupt-accept strobe opens an interrupt context. While it is open, all three domains run whatever the captured bits say. An interrupt-return strobe closes the context, and the saved low-power state then takes effect again. A DMA request can also wake a halted sub-main clock, but only when the wake option is enabled. All enables are registered, and each divided enable is a pulse one cycle wide, so a gating change never cuts a pulse short.

Top module: `lpm_clk_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cpu_run_en` is 1 and `aux_clk_en` and `sub_clk_en` are 0. The captured low-power bits and both divider counters are cleared.
- R2: One edge after `lp_cpu_off` is sampled high outside interrupt context, `cpu_run_en` goes low at the next edge and stays low while that condition holds.
- R3: When `lp_osc_off` has been captured as 1 outside interrupt context, `aux_clk_en` produces no pulse.
- R4: When `lp_sub_off` has been captured as 1 outside interrupt context, `sub_clk_en` produces no pulse, unless a DMA wake is active (R9).
- R5: `irq_accept` opens the interrupt context and `irq_return` closes it. While it is open, `cpu_run_en` is 1 and both clock enables pulse as if every low-power bit were 0. After the return, the halted domains stop again.
- R6: With `cfg_sub_direct` = 0, `sub_clk_en` gives one single-cycle pulse every SUB_DIV (default 8) cycles, so any 80-cycle window holds exactly 10 pulses.
- R7: With `cfg_sub_direct` = 1, `sub_clk_en` is high on every cycle it is not halted, so 104 cycles give 104 pulses. This holds whatever the value of `lp_osc_off`.
- R8: `aux_clk_en` gives one single-cycle pulse every AUX_DIV (default 32) cycles, so any 96-cycle window holds 3 pulses and any 104-cycle window holds 3 or 4.
- R9: When `dma_req` and `cfg_dma_wake` are both 1, a sub-main clock halted by `lp_sub_off` runs. With `cfg_dma_wake` = 0, `dma_req` has no effect on any enable.
- R10: When `irq_accept` and `irq_return` are high in the same cycle, the interrupt context is open afterwards, whatever its state before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_cpu_off | input | 1 | Status image CPU halt request |
| lp_osc_off | input | 1 | Status image auxiliary clock halt request |
| lp_sub_off | input | 1 | Status image sub-main clock halt request |
| irq_accept | input | 1 | Single-cycle interrupt accept strobe |
| irq_return | input | 1 | Single-cycle return-from-interrupt strobe |
| dma_req | input | 1 | DMA transfer request level |
| cfg_dma_wake | input | 1 | Allows DMA to wake the sub-main clock |
| cfg_sub_direct | input | 1 | Sub-main enable follows main clock undivided |
| cpu_run_en | output | 1 | CPU instruction-advance enable |
| aux_clk_en | output | 1 | Auxiliary low-rate clock enable pulse |
| sub_clk_en | output | 1 | Sub-main clock enable pulse |

## Verification
The accept and return strobes can land in the same cycle, as when a new interrupt is taken just as the current handler returns. The bench drives both together in two cases: with the context closed and with it open. It then checks that the CPU keeps running and that the sub-main and auxiliary pulses keep their full rate over the following windows. A second overlap comes from a DMA request while an interrupt context is open. Both overrides together must give the same sub-main rate as either one alone, and once both are gone the sub-main enable must stop.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // Captured low-power request bits
  typedef struct packed {
    logic sub_off;
    logic osc_off;
    logic cpu_off;
  } lp_bits_t;

  localparam int unsigned LPM_SUB_DIV_DEF = 8;
  localparam int unsigned LPM_AUX_DIV_DEF = 32;

endpackage

// File: rtl/lpm_irq_ctx.sv
module lpm_irq_ctx (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  input  logic return_i,
  output logic ctx_o
);

  logic ctx_q;

  // Accept takes priority over return so a back-to-back interrupt keeps service open
  always_ff @(posedge clk) begin
    if (rst)           ctx_q <= 1'b0;
    else if (accept_i) ctx_q <= 1'b1;
    else if (return_i) ctx_q <= 1'b0;
  end

  assign ctx_o = ctx_q;

  a_r10_accept_opens: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> ctx_o);

  a_r5_return_closes: assert property (@(posedge clk) disable iff (rst)
    (return_i && !accept_i) |=> !ctx_o);

endmodule

// File: rtl/lpm_en_div.sv
module lpm_en_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass_i,
  input  logic run_i,
  output logic en_o
);

  logic en_q;

  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned CNT_W = $clog2(DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt_q;
      logic             wrap;

      assign wrap = (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          en_q  <= 1'b0;
        end else begin
          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
          en_q  <= (wrap || bypass_i) && run_i;
        end
      end

      // R6/R8: a divided pulse that began on a wrap is never stretched
      a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (en_q && !bypass_i && cnt_q == '0) |=> !en_q);
    end else begin : g_nodiv
      always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= run_i;
      end
    end
  endgenerate

  assign en_o = en_q;

endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate #(
  parameter int unsigned SUB_DIV = lpm_pkg::LPM_SUB_DIV_DEF,
  parameter int unsigned AUX_DIV = lpm_pkg::LPM_AUX_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_cpu_off,
  input  logic lp_osc_off,
  input  logic lp_sub_off,
  input  logic irq_accept,
  input  logic irq_return,
  input  logic dma_req,
  input  logic cfg_dma_wake,
  input  logic cfg_sub_direct,
  output logic cpu_run_en,
  output logic aux_clk_en,
  output logic sub_clk_en
);

  import lpm_pkg::*;

  lp_bits_t lp_q;
  logic     in_ctx;
  logic     dma_wake;
  logic     cpu_run_req, aux_run_req, sub_run_req;
  logic     cpu_run_q;

  // Capture of the status image bits; reset clears them so every domain runs
  always_ff @(posedge clk) begin
    if (rst) lp_q <= '0;
    else     lp_q <= '{sub_off: lp_sub_off, osc_off: lp_osc_off, cpu_off: lp_cpu_off};
  end

  lpm_irq_ctx u_ctx (
    .clk      (clk),
    .rst      (rst),
    .accept_i (irq_accept),
    .return_i (irq_return),
    .ctx_o    (in_ctx)
  );

  assign dma_wake    = dma_req && cfg_dma_wake;
  assign cpu_run_req = !(lp_q.cpu_off && !in_ctx);
  assign aux_run_req = !(lp_q.osc_off && !in_ctx);
  assign sub_run_req = !(lp_q.sub_off && !in_ctx && !dma_wake);

  always_ff @(posedge clk) begin
    if (rst) cpu_run_q <= 1'b1;
    else     cpu_run_q <= cpu_run_req;
  end
  assign cpu_run_en = cpu_run_q;

  lpm_en_div #(.DIV(SUB_DIV)) u_sub_div (
    .clk      (clk),
    .rst      (rst),
    .bypass_i (cfg_sub_direct),
    .run_i    (sub_run_req),
    .en_o     (sub_clk_en)
  );

  lpm_en_div #(.DIV(AUX_DIV)) u_aux_div (
    .clk      (clk),
    .rst      (rst),
    .bypass_i (1'b0),
    .run_i    (aux_run_req),
    .en_o     (aux_clk_en)
  );

  a_r2_cpu_halts: assert property (@(posedge clk) disable iff (rst)
    (lp_q.cpu_off && !in_ctx) |=> !cpu_run_en);

  a_r3_aux_gated: assert property (@(posedge clk) disable iff (rst)
    (lp_q.osc_off && !in_ctx) |=> !aux_clk_en);

  a_r4_sub_gated: assert property (@(posedge clk) disable iff (rst)
    (lp_q.sub_off && !in_ctx && !dma_wake) |=> !sub_clk_en);

  a_r5_ctx_runs_cpu: assert property (@(posedge clk) disable iff (rst)
    in_ctx |=> cpu_run_en);

endmodule

// File: tb/lpm_clk_gate_tb.sv
`timescale 1ns/1ps
module lpm_clk_gate_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp_cpu_off = 0, lp_osc_off = 0, lp_sub_off = 0;
  logic irq_accept = 0, irq_return = 0, dma_req = 0;
  logic cfg_dma_wake = 0, cfg_sub_direct = 0;
  logic cpu_run_en, aux_clk_en, sub_clk_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  lpm_clk_gate dut_i (
    .clk(clk), .rst(rst),
    .lp_cpu_off(lp_cpu_off), .lp_osc_off(lp_osc_off), .lp_sub_off(lp_sub_off),
    .irq_accept(irq_accept), .irq_return(irq_return), .dma_req(dma_req),
    .cfg_dma_wake(cfg_dma_wake), .cfg_sub_direct(cfg_sub_direct),
    .cpu_run_en(cpu_run_en), .aux_clk_en(aux_clk_en), .sub_clk_en(sub_clk_en)
  );

  // Behavioural reference model, advanced on every rising edge
  bit m_cpu = 1, m_aux = 0, m_sub = 0;
  bit m_lcpu = 0, m_losc = 0, m_lsub = 0, m_ctx = 0;
  int m_sc = 0, m_ac = 0;

  always @(posedge clk) begin
    bit n_cpu, n_aux, n_sub, n_ctx;
    if (rst) begin
      m_cpu = 1; m_aux = 0; m_sub = 0;
      m_lcpu = 0; m_losc = 0; m_lsub = 0; m_ctx = 0;
      m_sc = 0; m_ac = 0;
    end else begin
      n_cpu = !(m_lcpu && !m_ctx);
      n_aux = (m_ac == 31) && !(m_losc && !m_ctx);
      n_sub = (cfg_sub_direct || m_sc == 7) &&
              !(m_lsub && !m_ctx && !(dma_req && cfg_dma_wake));
      if (irq_accept)      n_ctx = 1;
      else if (irq_return) n_ctx = 0;
      else                 n_ctx = m_ctx;
      m_sc = (m_sc + 1) % 8;
      m_ac = (m_ac + 1) % 32;
      m_cpu = n_cpu; m_aux = n_aux; m_sub = n_sub; m_ctx = n_ctx;
      m_lcpu = lp_cpu_off; m_losc = lp_osc_off; m_lsub = lp_sub_off;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R5 cpu_run_en model", cpu_run_en, m_cpu);
      chk("R3/R8 aux_clk_en model", aux_clk_en, m_aux);
      chk("R4/R6 sub_clk_en model", sub_clk_en, m_sub);
    end
  end

  int c_sub, c_aux, c_cpu;
  task automatic window(input int n);
    c_sub = 0; c_aux = 0; c_cpu = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_sub += sub_clk_en; c_aux += aux_clk_en; c_cpu += cpu_run_en;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit acc, input bit ret);
    irq_accept = acc; irq_return = ret;
    @(negedge clk);
    irq_accept = 0; irq_return = 0;
  endtask

  initial begin
    idle(4);
    // R1: reset state
    chk("R1 cpu_run_en in reset", cpu_run_en, 1);
    chk("R1 aux_clk_en in reset", aux_clk_en, 0);
    chk("R1 sub_clk_en in reset", sub_clk_en, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 cpu_run_en after reset", cpu_run_en, 1);
    chk("R1 sub_clk_en after reset", sub_clk_en, 0);

    // R6 / R8: free-running rates
    window(80);  chk("R6 sub pulses in 80", c_sub, 10);
    window(96);  chk("R8 aux pulses in 96", c_aux, 3);
    window(104); chk("R8 aux pulses in 104 low", (c_aux >= 3 && c_aux <= 4), 1);

    // R7 with R3: direct mode while auxiliary halted
    cfg_sub_direct = 1; lp_osc_off = 1;
    idle(3);
    window(104);
    chk("R7 direct sub pulses", c_sub, 104);
    chk("R3 aux halted", c_aux, 0);
    cfg_sub_direct = 0;

    // R4 and R2: halts
    lp_sub_off = 1; lp_cpu_off = 1;
    idle(3);
    window(80);
    chk("R4 sub halted", c_sub, 0);
    chk("R2 cpu halted", c_cpu, 0);

    // R9: DMA without wake option has no effect
    dma_req = 1;
    idle(2);
    window(80);
    chk("R9 dma ignored without wake", c_sub, 0);
    chk("R9 dma cpu unaffected", c_cpu, 0);
    cfg_dma_wake = 1;
    idle(2);
    window(80);
    chk("R9 dma wakes sub", c_sub, 10);
    chk("R9 dma aux still halted", c_aux, 0);
    dma_req = 0;

    // R5: interrupt context
    strobe(1, 0);
    idle(2);
    window(96);
    chk("R5 cpu runs in irq", c_cpu, 96);
    chk("R5 sub runs in irq", c_sub, 12);
    chk("R5 aux runs in irq", c_aux, 3);
    // DMA overlapping open context
    dma_req = 1;
    window(80);
    chk("R9 dma plus irq sub rate", c_sub, 10);
    dma_req = 0;
    // R10: simultaneous strobes with context open
    strobe(1, 1);
    idle(2);
    window(80);
    chk("R10 ctx stays open cpu", c_cpu, 80);
    chk("R10 ctx stays open sub", c_sub, 10);
    strobe(0, 1);
    idle(3);
    window(96);
    chk("R5 cpu stops after return", c_cpu, 0);
    chk("R5 sub stops after return", c_sub, 0);
    chk("R5 aux stops after return", c_aux, 0);
    // R10: simultaneous strobes with context closed
    strobe(1, 1);
    idle(2);
    window(96);
    chk("R10 ctx opened cpu", c_cpu, 96);
    chk("R10 ctx opened aux", c_aux, 3);
    strobe(0, 1);

    // Release halts: everything runs again
    lp_cpu_off = 0; lp_osc_off = 0; lp_sub_off = 0;
    idle(3);
    window(96);
    chk("R2 cpu resumes", c_cpu, 96);
    chk("R6 sub resumes", c_sub, 12);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule